// File: doc/BRIEF.md
# Converter Sample/Convert Sequencer with Result Formatter

This block is the digital controller that sits in front of an external analog-to-digital converter. It holds the converter in a sample phase and picks the event that closes that phase from a 3-bit source select. The event can be a software strobe, a rising edge on an external interrupt line, a pulse from one of two timers, a pulse from one of two PWM generators, or an internal sample-time counter. A fixed settling gap follows. The block then raises a conversion request and holds it until the converter answers with a done strobe and its raw code.

The raw code is offset binary, either 10 or 12 bits wide. It is remapped into a 16-bit word in one of four layouts: right-justified unsigned, right-justified signed, left-justified unsigned fraction, or left-justified signed fraction. The word comes out with a one-cycle valid strobe and a sticky done flag. When auto-sampling is on, a new sample phase begins as soon as a conversion ends. Otherwise the block waits for software to set the sample bit again.

Top module: `adc_seq_top`

## Requirements
- R1: While `en` is 0, `sampling`, `conv_req`, `done` and `res_valid` are 0 one cycle later, and `samp_set` has no effect.
- R2: From idle with `en`=1, a cycle with `samp_set`=1 (or `auto_samp`=1) makes `sampling` 1 in the next cycle and clears `done` at the same edge.
- R3: With `src_sel`=000, only `samp_clr` ends sampling; timer, PWM and interrupt inputs are ignored.
- R4: With `src_sel`=001, only a 0-to-1 transition of `ext_int` ends sampling; a level held high does not.
- R5: Selects 010 and 100 end sampling on `tmr_a` and `tmr_b` respectively; selects 011 and 101 end it on `pwm_a` and `pwm_b`; each select ignores the other three event inputs.
- R6: With `src_sel`=111, `sampling` stays high for exactly `samp_time` cycles, and a value of 0 counts as 1.
- R7: With `src_sel`=110, no input ever ends sampling; only `en`=0 leaves it.
- R8: After sampling ends, HOLD_CYC cycles pass with `sampling` and `conv_req` both 0. Then `conv_req` stays 1 until a cycle with `conv_done`=1.
- R9: `res_valid` is a one-cycle pulse in the cycle after `conv_done` is accepted. `done` rises with it and stays 1 until the next idle-to-sampling start.
- R10: Format 00 gives the code right-justified with zeros above it.
- R11: Format 10 gives the code left-justified (bit 15 down) with zeros below it.
- R12: Formats 01 and 11 invert the code's top bit and treat it as a sign. Format 01 sign-extends it right-justified. Format 11 places it at bit 15 left-justified.
- R13: With `auto_samp`=1, `sampling` is 1 in the same cycle that `res_valid` is 1.
- R14: `res12`=1 uses `conv_data[11:0]`. `res12`=0 uses `conv_data[9:0]` and ignores bits 11:10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable |
| res12 | input | 1 | 1 = 12-bit codes, 0 = 10-bit codes |
| fmt | input | 2 | Output layout select |
| src_sel | input | 3 | Sample-end event select |
| auto_samp | input | 1 | Restart sampling after each conversion |
| samp_time | input | CNT_W | Auto sample length in cycles |
| samp_set | input | 1 | Software strobe that starts sampling |
| samp_clr | input | 1 | Software strobe that ends sampling |
| ext_int | input | 1 | External interrupt line (edge used) |
| tmr_a | input | 1 | Timer A compare pulse |
| tmr_b | input | 1 | Timer B compare pulse |
| pwm_a | input | 1 | PWM A interval pulse |
| pwm_b | input | 1 | PWM B interval pulse |
| conv_req | output | 1 | Conversion request to the converter |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | RAW_W | Raw offset-binary code |
| sampling | output | 1 | Sample phase active |
| done | output | 1 | Sticky conversion-complete flag |
| res_valid | output | 1 | Formatted word valid strobe |
| res_word | output | OUT_W | Formatted result |

## Verification
The assertions assume that `conv_done` is a single-cycle pulse that appears only while `conv_req` is high. They also assume that timer and PWM inputs are single-cycle pulses, and that `src_sel`, `fmt`, `res12` and `samp_time` change only while no sequence is running. The bench's converter model answers each request once, after a fixed latency, and drops its strobe the next cycle. The stimulus changes configuration only between sequences, apart from dropping `en` while a sample phase is active. Every event input is pulsed one cycle at a time, except `ext_int`, which is held high on purpose to probe the edge rule.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SAMP = 2'd1,
    PH_HOLD = 2'd2,
    PH_CONV = 2'd3
  } phase_t;

  localparam logic [2:0] SRC_SW   = 3'b000;
  localparam logic [2:0] SRC_EXT  = 3'b001;
  localparam logic [2:0] SRC_TMRA = 3'b010;
  localparam logic [2:0] SRC_PWMA = 3'b011;
  localparam logic [2:0] SRC_TMRB = 3'b100;
  localparam logic [2:0] SRC_PWMB = 3'b101;
  localparam logic [2:0] SRC_RSVD = 3'b110;
  localparam logic [2:0] SRC_AUTO = 3'b111;

  localparam logic [1:0] FMT_UINT  = 2'b00;
  localparam logic [1:0] FMT_SINT  = 2'b01;
  localparam logic [1:0] FMT_UFRAC = 2'b10;
  localparam logic [1:0] FMT_SFRAC = 2'b11;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] src_sel,
  input  logic       samp_clr,
  input  logic       ext_int,
  input  logic       tmr_a,
  input  logic       tmr_b,
  input  logic       pwm_a,
  input  logic       pwm_b,
  input  logic       auto_hit,
  output logic       end_evt
);
  logic       ext_q;
  logic       ext_rise;
  logic [7:0] cand;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_int;
  end

  assign ext_rise = ext_int & ~ext_q;

  always_comb begin
    cand           = '0;
    cand[SRC_SW]   = samp_clr;
    cand[SRC_EXT]  = ext_rise;
    cand[SRC_TMRA] = tmr_a;
    cand[SRC_PWMA] = pwm_a;
    cand[SRC_TMRB] = tmr_b;
    cand[SRC_PWMB] = pwm_b;
    cand[SRC_RSVD] = 1'b0;
    cand[SRC_AUTO] = auto_hit;
  end

  assign end_evt = cand[src_sel];

  // R4: a held-high interrupt line gives no further event
  p_ext_level_r4: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_EXT && $past(ext_int) && ext_int) |-> !end_evt);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             samp_set,
  input  logic             auto_samp,
  input  logic [CNT_W-1:0] samp_time,
  input  logic             end_evt,
  input  logic             conv_done,
  output logic             auto_hit,
  output logic             sampling,
  output logic             conv_req,
  output logic             cap,
  output logic             done
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  phase_t           st;
  logic [CNT_W-1:0] scnt;
  logic [CNT_W-1:0] tgt;
  logic [HW-1:0]    hcnt;
  logic             hold_end;

  assign tgt      = (samp_time == '0) ? CNT_W'(1) : samp_time;
  assign auto_hit = (st == PH_SAMP) && (scnt == tgt - CNT_W'(1));
  assign hold_end = (hcnt == HW'(HOLD_CYC - 1));
  assign cap      = en && (st == PH_CONV) && conv_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PH_IDLE;
      scnt <= '0;
      hcnt <= '0;
      done <= 1'b0;
    end else if (!en) begin
      st   <= PH_IDLE;
      done <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: begin
          if (samp_set || auto_samp) begin
            st   <= PH_SAMP;
            scnt <= '0;
            done <= 1'b0;
          end
        end
        PH_SAMP: begin
          if (end_evt) begin
            st   <= PH_HOLD;
            hcnt <= '0;
          end else begin
            scnt <= scnt + CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (hold_end) st <= PH_CONV;
          else          hcnt <= hcnt + HW'(1);
        end
        PH_CONV: begin
          if (conv_done) begin
            done <= 1'b1;
            if (auto_samp) begin
              st   <= PH_SAMP;
              scnt <= '0;
            end else begin
              st <= PH_IDLE;
            end
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign sampling = (st == PH_SAMP);
  assign conv_req = (st == PH_CONV);

  // R1: disable forces everything quiet
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sampling && !conv_req && !done));
  // R8: request is held until the converter answers
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && conv_req && !conv_done) |=> conv_req);
  // R8: end of sampling is followed by a gap, not an immediate request
  p_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (en && sampling && end_evt) |=> (!conv_req && !sampling));
  // R9: an accepted completion raises the flag
  p_done_set_r9: assert property (@(posedge clk) disable iff (rst)
    cap |=> done);
endmodule

// File: rtl/adc_fmt.sv
module adc_fmt
  import adc_seq_pkg::*;
#(
  parameter int RAW_W    = 12,
  parameter int NARROW_W = 10,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             res12,
  input  logic [1:0]       fmt,
  input  logic [RAW_W-1:0] raw,
  output logic             valid,
  output logic [OUT_W-1:0] word
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int W   = (g == 0) ? NARROW_W : RAW_W;
    localparam int PAD = OUT_W - W;
    logic [W-1:0]     v;
    logic [W-1:0]     vf;
    logic [OUT_W-1:0] w;

    assign v  = raw[W-1:0];
    assign vf = {~v[W-1], v[W-2:0]};

    always_comb begin
      case (fmt)
        FMT_UINT:  w = {{PAD{1'b0}}, v};
        FMT_SINT:  w = {{PAD{vf[W-1]}}, vf};
        FMT_UFRAC: w = {v, {PAD{1'b0}}};
        default:   w = {vf, {PAD{1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      word  <= '0;
    end else begin
      valid <= cap;
      if (cap) word <= res12 ? g_lane[1].w : g_lane[0].w;
    end
  end

  // R9: valid never lasts two cycles
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R10: unsigned narrow result has clear upper bits
  p_int_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (cap && fmt == FMT_UINT && !res12) |=> (word[OUT_W-1:NARROW_W] == '0));
  // R11: fraction layout leaves low bits clear
  p_frac_fill_r11: assert property (@(posedge clk) disable iff (rst)
    (cap && fmt == FMT_UFRAC && res12) |=> (word[OUT_W-RAW_W-1:0] == '0));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int HOLD_CYC = 2,
  parameter int RAW_W    = 12,
  parameter int NARROW_W = 10,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             res12,
  input  logic [1:0]       fmt,
  input  logic [2:0]       src_sel,
  input  logic             auto_samp,
  input  logic [CNT_W-1:0] samp_time,
  input  logic             samp_set,
  input  logic             samp_clr,
  input  logic             ext_int,
  input  logic             tmr_a,
  input  logic             tmr_b,
  input  logic             pwm_a,
  input  logic             pwm_b,
  output logic             conv_req,
  input  logic             conv_done,
  input  logic [RAW_W-1:0] conv_data,
  output logic             sampling,
  output logic             done,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_word
);
  logic auto_hit;
  logic end_evt;
  logic cap;

  adc_trig_sel u_trig (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (src_sel),
    .samp_clr (samp_clr),
    .ext_int  (ext_int),
    .tmr_a    (tmr_a),
    .tmr_b    (tmr_b),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b),
    .auto_hit (auto_hit),
    .end_evt  (end_evt)
  );

  adc_seq_fsm #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .samp_set  (samp_set),
    .auto_samp (auto_samp),
    .samp_time (samp_time),
    .end_evt   (end_evt),
    .conv_done (conv_done),
    .auto_hit  (auto_hit),
    .sampling  (sampling),
    .conv_req  (conv_req),
    .cap       (cap),
    .done      (done)
  );

  adc_fmt #(.RAW_W(RAW_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_fmt (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap),
    .res12 (res12),
    .fmt   (fmt),
    .raw   (conv_data),
    .valid (res_valid),
    .word  (res_word)
  );

  // R7: the reserved select never closes the sample phase
  p_rsvd_r7: assert property (@(posedge clk) disable iff (rst)
    (en && sampling && src_sel == SRC_RSVD) |=> sampling);
  // R3: software clear ends sampling when selected
  p_sw_end_r3: assert property (@(posedge clk) disable iff (rst)
    (en && sampling && src_sel == SRC_SW && samp_clr) |=> !sampling);
  // R13: auto restart overlaps the result strobe
  p_auto_r13: assert property (@(posedge clk) disable iff (rst)
    (en && cap && auto_samp) |=> sampling);
endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  localparam int HOLD = 2;
  localparam int LAT  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, res12 = 1'b0, auto_samp = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [2:0]  src_sel = 3'b000;
  logic [4:0]  samp_time = 5'd1;
  logic        samp_set = 1'b0, samp_clr = 1'b0, ext_int = 1'b0;
  logic        tmr_a = 1'b0, tmr_b = 1'b0, pwm_a = 1'b0, pwm_b = 1'b0;
  logic        conv_req, conv_done = 1'b0;
  logic [11:0] conv_data = 12'h000;
  logic        sampling, done, res_valid;
  logic [15:0] res_word;

  always #5 clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rst(rst), .en(en), .res12(res12), .fmt(fmt), .src_sel(src_sel),
    .auto_samp(auto_samp), .samp_time(samp_time), .samp_set(samp_set),
    .samp_clr(samp_clr), .ext_int(ext_int), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .conv_req(conv_req), .conv_done(conv_done),
    .conv_data(conv_data), .sampling(sampling), .done(done),
    .res_valid(res_valid), .res_word(res_word)
  );

  int    n_chk = 0, n_fail = 0;
  bit    started = 0, finished = 0;
  string cur = "R2";

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_fmt(logic [11:0] d, logic r12, logic [1:0] f);
    int w, v, half;
    w    = r12 ? 12 : 10;
    v    = r12 ? int'(d) : int'(d[9:0]);
    half = 1 << (w - 1);
    case (f)
      2'b00:   return 16'(v);
      2'b01:   return 16'(v - half);
      2'b10:   return 16'(v << (16 - w));
      default: return 16'((v ^ half) << (16 - w));
    endcase
  endfunction

  function automatic logic [11:0] pick_code(int k);
    case (k % 8)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      4: return 12'hA5C;
      5: return 12'h3FF;
      6: return 12'h200;
      default: return 12'h1FF;
    endcase
  endfunction

  // behavioural converter
  int cv_phase = 0, cv_cnt = 0, cv_idx = 0;
  logic [11:0] last_raw = 12'h0;
  always @(negedge clk) begin
    if (cv_phase == 0) begin
      if (conv_req) begin cv_phase = 1; cv_cnt = LAT; end
    end else if (cv_phase == 1) begin
      if (cv_cnt == 0) begin
        conv_data = pick_code(cv_idx);
        last_raw  = conv_data;
        cv_idx++;
        conv_done = 1'b1;
        cv_phase  = 2;
      end else cv_cnt--;
    end else begin
      conv_done = 1'b0;
      if (!conv_req) cv_phase = 0;
    end
  end

  // reference model: phase 0 idle, 1 sample, 2 hold, 3 convert
  int   ph = 0, m_cnt = 0, m_hc = 0, eff = 1;
  logic m_done = 0, m_valid = 0, m_ext_prev = 0, evt = 0;
  logic [15:0] m_word = 0;
  always @(posedge clk) begin
    m_valid = 1'b0;
    if (rst) begin
      ph = 0; m_done = 0; m_word = 0; m_cnt = 0; m_hc = 0;
    end else if (!en) begin
      ph = 0; m_done = 0;
    end else begin
      case (ph)
        0: if (samp_set || auto_samp) begin ph = 1; m_cnt = 0; m_done = 0; end
        1: begin
          eff = (samp_time == 0) ? 1 : int'(samp_time);
          case (src_sel)
            3'd0: evt = samp_clr;
            3'd1: evt = ext_int && !m_ext_prev;
            3'd2: evt = tmr_a;
            3'd3: evt = pwm_a;
            3'd4: evt = tmr_b;
            3'd5: evt = pwm_b;
            3'd7: evt = (m_cnt + 1 == eff);
            default: evt = 1'b0;
          endcase
          if (evt) begin ph = 2; m_hc = 0; end else m_cnt++;
        end
        2: if (m_hc == HOLD - 1) ph = 3; else m_hc++;
        default: if (conv_done) begin
          m_done = 1; m_valid = 1;
          m_word = ref_fmt(conv_data, res12, fmt);
          ph = auto_samp ? 1 : 0; m_cnt = 0;
        end
      endcase
    end
    m_ext_prev = rst ? 1'b0 : ext_int;
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(cur,  "sampling",  {15'd0, sampling},  {15'd0, ph == 1});
      chk("R8", "conv_req",  {15'd0, conv_req},  {15'd0, ph == 3});
      chk("R9", "done",      {15'd0, done},      {15'd0, m_done});
      chk("R9", "res_valid", {15'd0, res_valid}, {15'd0, m_valid});
      if (m_valid) chk(cur, "res_word", res_word, m_word);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_set();
    samp_set = 1'b1; tick(1); samp_set = 1'b0;
  endtask
  task automatic wait_valid();
    for (int i = 0; i < 200; i++) begin
      if (res_valid) return;
      tick(1);
    end
  endtask
  task automatic pulse_others(input int skip);
    if (skip != 2) begin tmr_a = 1; tick(1); tmr_a = 0; end
    if (skip != 3) begin pwm_a = 1; tick(1); pwm_a = 0; end
    if (skip != 4) begin tmr_b = 1; tick(1); tmr_b = 0; end
    if (skip != 5) begin pwm_b = 1; tick(1); pwm_b = 0; end
    if (skip != 0) begin samp_clr = 1; tick(1); samp_clr = 0; end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1", "reset sampling", {15'd0, sampling}, 16'd0);
    chk("R1", "reset conv_req", {15'd0, conv_req}, 16'd0);
    chk("R1", "reset done", {15'd0, done}, 16'd0);
    chk("R1", "reset valid", {15'd0, res_valid}, 16'd0);
    started = 1;

    cur = "R1";
    pulse_set(); tick(2);
    chk("R1", "set ignored while off", {15'd0, sampling}, 16'd0);

    en = 1'b1; src_sel = 3'b000; fmt = 2'b00; tick(2);
    cur = "R2"; pulse_set();
    chk("R2", "sampling after set", {15'd0, sampling}, 16'd1);
    cur = "R3"; tick(2);
    tmr_a = 1; tick(1); tmr_a = 0;
    pwm_b = 1; tick(1); pwm_b = 0;
    ext_int = 1; tick(1); ext_int = 0;
    chk("R3", "other events ignored", {15'd0, sampling}, 16'd1);
    samp_clr = 1; tick(1); samp_clr = 0;
    chk("R3", "clear ends sampling", {15'd0, sampling}, 16'd0);
    wait_valid(); tick(1);
    chk("R9", "done after conversion", {15'd0, done}, 16'd1);

    cur = "R4"; src_sel = 3'b001; ext_int = 1; tick(2);
    pulse_set(); tick(4);
    chk("R4", "held level ignored", {15'd0, sampling}, 16'd1);
    chk("R9", "done cleared on start", {15'd0, done}, 16'd0);
    ext_int = 0; tick(2); ext_int = 1; tick(1);
    chk("R4", "rising edge ends", {15'd0, sampling}, 16'd0);
    ext_int = 0; wait_valid(); tick(3);

    cur = "R5";
    for (int s = 2; s <= 5; s++) begin
      src_sel = 3'(s); tick(1);
      pulse_set(); pulse_others(s);
      chk("R5", "foreign events ignored", {15'd0, sampling}, 16'd1);
      case (s)
        2: begin tmr_a = 1; tick(1); tmr_a = 0; end
        3: begin pwm_a = 1; tick(1); pwm_a = 0; end
        4: begin tmr_b = 1; tick(1); tmr_b = 0; end
        default: begin pwm_b = 1; tick(1); pwm_b = 0; end
      endcase
      chk("R5", "own event ends", {15'd0, sampling}, 16'd0);
      wait_valid(); tick(3);
    end

    cur = "R6"; src_sel = 3'b111;
    for (int t = 0; t < 4; t++) begin
      samp_time = (t == 0) ? 5'd1 : (t == 1) ? 5'd5 : (t == 2) ? 5'd0 : 5'd31;
      tick(1); pulse_set(); wait_valid(); tick(3);
    end

    cur = "R7"; src_sel = 3'b110; tick(1);
    pulse_set(); pulse_others(6);
    ext_int = 1; tick(1); ext_int = 0; tick(5);
    chk("R7", "reserved never ends", {15'd0, sampling}, 16'd1);
    en = 1'b0; tick(2);
    chk("R1", "disable leaves sampling", {15'd0, sampling}, 16'd0);
    en = 1'b1; tick(1);

    cur = "R14"; src_sel = 3'b111; samp_time = 5'd3;
    for (int r = 0; r < 2; r++) begin
      for (int f = 0; f < 4; f++) begin
        for (int k = 0; k < 3; k++) begin
          res12 = r[0]; fmt = 2'(f); tick(1);
          pulse_set(); wait_valid();
          chk((f == 0) ? "R10" : (f == 2) ? "R11" : "R12", "format word",
              res_word, ref_fmt(last_raw, r[0], 2'(f)));
          tick(2);
        end
      end
    end

    cur = "R13"; res12 = 1'b0; fmt = 2'b01; samp_time = 5'd2; auto_samp = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(1); wait_valid();
      chk("R13", "restart with result", {15'd0, sampling}, 16'd1);
    end
    auto_samp = 1'b0; tick(40);
    chk("R13", "idle after auto off", {15'd0, sampling}, 16'd0);
    chk("R9", "done held in idle", {15'd0, done}, 16'd1);

    tick(2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule